// File: doc/BRIEF.md
# RS-485 Address Filter and Transceiver Direction Control

This block sits beside a UART in a half-duplex RS-485 node. On the receive side it takes finished characters from the deserializer, each with its eight data bits and the ninth (parity-position) bit, and decides what reaches the receive FIFO. In multidrop mode a character whose ninth bit is 1 is treated as an address and raises an address interrupt pulse. With automatic address matching on, an address is compared with a programmed 8-bit station value. A hit opens the receiver and a miss closes it, so data meant for other stations is discarded.

On the transmit side it drives the transceiver's driver-enable line. The line can be placed on the RTS pin or the DTR pin, and its polarity is programmable. After the transmitter goes idle, the line stays in the transmit state for a programmable number of bit times, counted on the baud bit strobe. This covers the line turn-around. The serializer, the FIFOs and the register interface are outside this block.

Top module: `rs485_link_ctrl`

## Requirements
- R1: After reset, no FIFO write and no address pulse is produced, the automatic match state is closed, and the direction line is in its receive level.
- R2: With multidrop mode off, every received character not blocked by the receiver-off control is written to the FIFO one clock after its valid strobe, with the same data, and no address pulse is produced.
- R3: In multidrop mode with automatic matching off, every character is written to the FIFO, and the address pulse fires in the same cycle as the write exactly when the ninth bit is 1.
- R4: While receiver-off is 1, received characters produce neither a FIFO write nor an address pulse, and the receiver-enabled output reads 0.
- R5: In automatic mode (multidrop and automatic matching both on), an address character whose data equals the match value is written to the FIFO, raises the address pulse, and opens the receiver.
- R6: In automatic mode, an address character that differs from the match value is not written, raises no pulse and closes the receiver; data characters (ninth bit 0) are then discarded.
- R7: In automatic mode, data characters are written only while the receiver is open. The open state is cleared while automatic mode is off, so a new match is needed after it is re-entered.
- R8: The direction line enters the transmit state one clock after the transmitter-busy input is seen high. With the invert control at 0 the transmit level is 0 and the receive level is 1; with invert at 1 these are swapped.
- R9: With direction control enabled, the select bit places the direction line on RTS (0) or DTR (1) and the other pin follows its modem input. With direction control disabled, both pins follow their modem inputs.
- R10: With a hold value N greater than 0, after busy falls the line stays in the transmit state until the Nth bit strobe that follows, and returns to the receive level in the next cycle.
- R11: With a hold value of 0, the line returns to the receive level one clock after busy is seen low.
- R12: Busy rising during the hold countdown cancels it. The line stays in the transmit state, and the next fall of busy starts a full new countdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mdrop_en_i | input | 1 | Multidrop mode: ninth bit marks an address |
| auto_match_en_i | input | 1 | Automatic address matching |
| rx_off_i | input | 1 | Receiver off when 1 |
| station_addr_i | input | 8 | Address match value |
| dir_en_i | input | 1 | Direction control enable |
| dir_on_dtr_i | input | 1 | Direction pin select: 0 RTS, 1 DTR |
| dir_invert_i | input | 1 | Direction level invert |
| hold_bits_i | input | 8 | Bit times the line stays in transmit state after busy falls |
| rx_valid_i | input | 1 | Received character strobe |
| rx_data_i | input | 8 | Received character data |
| rx_ninth_i | input | 1 | Received ninth bit |
| tx_busy_i | input | 1 | Transmitter holds or is sending data |
| bit_tick_i | input | 1 | Baud bit strobe |
| rts_mdm_i | input | 1 | Modem-control level for RTS |
| dtr_mdm_i | input | 1 | Modem-control level for DTR |
| fifo_wr_o | output | 1 | Receive FIFO write strobe |
| fifo_data_o | output | 8 | Receive FIFO write data |
| addr_irq_o | output | 1 | Address character pulse |
| rx_enabled_o | output | 1 | Receiver currently accepting data |
| rts_o | output | 1 | RTS pin |
| dtr_o | output | 1 | DTR pin |

## Verification
A stuck or wrong match state shows one clock after the next data character. It appears as a missing or extra FIFO write, and it is also visible on the receiver-enabled output. A miscounted hold counter moves the release edge of RTS or DTR by whole bit strobes, so it shows within the turn-around window of the first frame. A wrong state after a cancelled countdown shows as an early release during the following transmission. The bench runs a cycle-accurate model alongside the block and compares every output in every cycle. Any divergence is therefore reported in the cycle where it first appears.

// File: rtl/rs485_pkg.sv
package rs485_pkg;
  typedef enum logic [1:0] {
    DIR_IDLE = 2'd0,
    DIR_TX   = 2'd1,
    DIR_HOLD = 2'd2
  } dir_state_e;
endpackage

// File: rtl/rs485_addr_filter.sv
module rs485_addr_filter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mdrop_en_i,
  input  logic              auto_match_en_i,
  input  logic              rx_off_i,
  input  logic [DATA_W-1:0] station_addr_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_ninth_i,
  output logic              wr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              irq_o,
  output logic              accept_o
);
  logic auto_mode, take, is_addr, hit;
  logic open_q, open_d, wr_d, irq_d;

  assign auto_mode = mdrop_en_i & auto_match_en_i;
  assign take      = rx_valid_i & ~rx_off_i;
  assign is_addr   = mdrop_en_i & rx_ninth_i;
  assign hit       = (rx_data_i == station_addr_i);

  always_comb begin
    open_d = open_q;
    wr_d   = 1'b0;
    irq_d  = 1'b0;
    if (!auto_mode) open_d = 1'b0;
    else if (take && is_addr) open_d = hit;
    if (take) begin
      if (!auto_mode) begin
        wr_d  = 1'b1;
        irq_d = is_addr;
      end else if (is_addr) begin
        wr_d  = hit;
        irq_d = hit;
      end else begin
        wr_d  = open_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      wr_o   <= 1'b0;
      irq_o  <= 1'b0;
      data_o <= '0;
    end else begin
      open_q <= open_d;
      wr_o   <= wr_d;
      irq_o  <= irq_d;
      if (take) data_o <= rx_data_i;
    end
  end

  assign accept_o = ~rx_off_i & (~auto_mode | open_q);

  assert_off_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_off_i) |=> (!wr_o && !irq_o));

  assert_plain_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !rx_off_i && !mdrop_en_i) |=> (wr_o && !irq_o && data_o == $past(rx_data_i)));

  assert_addr_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !rx_off_i && mdrop_en_i && auto_match_en_i && rx_ninth_i &&
     rx_data_i == station_addr_i) |=> (wr_o && irq_o && open_q));

  assert_addr_miss_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !rx_off_i && mdrop_en_i && auto_match_en_i && rx_ninth_i &&
     rx_data_i != station_addr_i) |=> (!wr_o && !irq_o && !open_q));

  assert_irq_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(mdrop_en_i) && $past(rx_ninth_i) && wr_o));
endmodule

// File: rtl/rs485_hold_cnt.sv
module rs485_hold_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   next_cnt;

  assign next_cnt = {1'b0, cnt_q} + 1'b1;
  // >= so a limit lowered mid-count still terminates
  assign done_o   = tick_i & (next_cnt >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (clr_i)        cnt_q <= '0;
    else if (tick_i && !done_o) cnt_q <= next_cnt[CNT_W-1:0];
  end

  assert_cnt_cleared_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
  import rs485_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_busy_i,
  input  logic             bit_tick_i,
  input  logic [CNT_W-1:0] hold_bits_i,
  output logic             active_o
);
  dir_state_e state_q, state_d;
  logic done;

  rs485_hold_cnt #(.CNT_W(CNT_W)) u_hold_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (state_q != DIR_HOLD),
    .tick_i  (bit_tick_i),
    .limit_i (hold_bits_i),
    .done_o  (done)
  );

  always_comb begin
    state_d = state_q;
    if (tx_busy_i) state_d = DIR_TX;
    else begin
      unique case (state_q)
        DIR_TX:   state_d = (hold_bits_i == '0) ? DIR_IDLE : DIR_HOLD;
        DIR_HOLD: state_d = done ? DIR_IDLE : DIR_HOLD;
        default:  state_d = DIR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= DIR_IDLE;
    else         state_q <= state_d;
  end

  assign active_o = (state_q != DIR_IDLE);

  assert_busy_active_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy_i |=> active_o);

  assert_zero_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == DIR_TX && !tx_busy_i && hold_bits_i == '0) |=> !active_o);

  assert_hold_wait_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == DIR_HOLD && !tx_busy_i && !bit_tick_i) |=> (state_q == DIR_HOLD));

  assert_cancel_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == DIR_HOLD && tx_busy_i) |=> (state_q == DIR_TX));
endmodule

// File: rtl/rs485_link_ctrl.sv
module rs485_link_ctrl #(
  parameter int DATA_W = 8,
  parameter int HOLD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mdrop_en_i,
  input  logic              auto_match_en_i,
  input  logic              rx_off_i,
  input  logic [DATA_W-1:0] station_addr_i,
  input  logic              dir_en_i,
  input  logic              dir_on_dtr_i,
  input  logic              dir_invert_i,
  input  logic [HOLD_W-1:0] hold_bits_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_ninth_i,
  input  logic              tx_busy_i,
  input  logic              bit_tick_i,
  input  logic              rts_mdm_i,
  input  logic              dtr_mdm_i,
  output logic              fifo_wr_o,
  output logic [DATA_W-1:0] fifo_data_o,
  output logic              addr_irq_o,
  output logic              rx_enabled_o,
  output logic              rts_o,
  output logic              dtr_o
);
  logic dir_active, dir_level;

  rs485_addr_filter #(.DATA_W(DATA_W)) u_addr_filter (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .mdrop_en_i      (mdrop_en_i),
    .auto_match_en_i (auto_match_en_i),
    .rx_off_i        (rx_off_i),
    .station_addr_i  (station_addr_i),
    .rx_valid_i      (rx_valid_i),
    .rx_data_i       (rx_data_i),
    .rx_ninth_i      (rx_ninth_i),
    .wr_o            (fifo_wr_o),
    .data_o          (fifo_data_o),
    .irq_o           (addr_irq_o),
    .accept_o        (rx_enabled_o)
  );

  rs485_dir_fsm #(.CNT_W(HOLD_W)) u_dir_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tx_busy_i   (tx_busy_i),
    .bit_tick_i  (bit_tick_i),
    .hold_bits_i (hold_bits_i),
    .active_o    (dir_active)
  );

  // normal polarity: 0 while transmitting
  assign dir_level = dir_invert_i ? dir_active : ~dir_active;
  assign rts_o = (dir_en_i && !dir_on_dtr_i) ? dir_level : rts_mdm_i;
  assign dtr_o = (dir_en_i &&  dir_on_dtr_i) ? dir_level : dtr_mdm_i;

  assert_rts_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_en_i && !dir_on_dtr_i && $past(tx_busy_i)) |-> (rts_o == dir_invert_i));

  assert_dtr_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_en_i && dir_on_dtr_i && $past(tx_busy_i)) |-> (dtr_o == dir_invert_i));

  assert_unused_pin_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_en_i) |-> (rts_o == rts_mdm_i && dtr_o == dtr_mdm_i));
endmodule

// File: tb/rs485_link_ctrl_bench.sv
`timescale 1ns/1ps
module rs485_link_ctrl_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  logic md = 0, aad = 0, off = 0, den = 0, sel = 0, inv = 0;
  logic [7:0] match = 0, hold = 0, rxd = 0;
  logic rxv = 0, nin = 0, busy = 0, tick = 0, rtsin = 0, dtrin = 0;
  logic fifo_wr, addr_irq, rx_en, rts, dtr;
  logic [7:0] fifo_data;

  rs485_link_ctrl u_rs485_link_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .mdrop_en_i(md), .auto_match_en_i(aad), .rx_off_i(off), .station_addr_i(match),
    .dir_en_i(den), .dir_on_dtr_i(sel), .dir_invert_i(inv), .hold_bits_i(hold),
    .rx_valid_i(rxv), .rx_data_i(rxd), .rx_ninth_i(nin),
    .tx_busy_i(busy), .bit_tick_i(tick), .rts_mdm_i(rtsin), .dtr_mdm_i(dtrin),
    .fifo_wr_o(fifo_wr), .fifo_data_o(fifo_data), .addr_irq_o(addr_irq),
    .rx_enabled_o(rx_en), .rts_o(rts), .dtr_o(dtr)
  );

  int checks = 0, errors = 0;
  logic m_open = 0, m_wr = 0, m_irq = 0;
  logic [7:0] m_data = 0;
  int m_st = 0;   // 0 idle, 1 tx, 2 hold
  int m_cnt = 0;

  function automatic logic exp_rx_en();
    return !off && (!(md && aad) || m_open);
  endfunction
  function automatic logic dir_lvl();
    logic act = (m_st != 0);
    return inv ? act : !act;
  endfunction
  function automatic logic exp_rts();
    return (den && !sel) ? dir_lvl() : rtsin;
  endfunction
  function automatic logic exp_dtr();
    return (den && sel) ? dir_lvl() : dtrin;
  endfunction

  task automatic model_step();
    logic am = md && aad;
    logic take = rxv && !off;
    logic isa = md && nin;
    logic hit = (rxd == match);
    logic nwr = 0, nirq = 0, nopen = m_open;
    if (!am) nopen = 0; else if (take && isa) nopen = hit;
    if (take) begin
      if (!am) begin nwr = 1; nirq = isa; end
      else if (isa) begin nwr = hit; nirq = hit; end
      else nwr = m_open;
      m_data = rxd;
    end
    m_wr = nwr; m_irq = nirq; m_open = nopen;
    if (busy) begin m_st = 1; m_cnt = 0; end
    else if (m_st == 1) begin m_st = (hold == 0) ? 0 : 2; m_cnt = 0; end
    else if (m_st == 2 && tick) begin
      if (m_cnt + 1 >= int'(hold)) begin m_st = 0; m_cnt = 0; end
      else m_cnt = m_cnt + 1;
    end
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "fifo_wr", fifo_wr, m_wr);
    if (m_wr) chk(tag, "fifo_data", fifo_data, m_data);
    chk(tag, "addr_irq", addr_irq, m_irq);
    chk(tag, "rx_enabled", rx_en, exp_rx_en());
    chk(tag, "rts", rts, exp_rts());
    chk(tag, "dtr", dtr, exp_dtr());
  endtask

  task automatic cyc(input string tag);
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    compare(tag);
    rxv = 0; tick = 0;
  endtask

  task automatic rx(input string tag, input logic [7:0] d, input logic n);
    rxv = 1; rxd = d; nin = n;
    cyc(tag);
    cyc(tag);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0485));
    repeat (3) @(negedge clk_i);
    den = 1; rtsin = 0; dtrin = 1;
    rst_ni = 1;
    @(negedge clk_i);
    compare("R1");
    // R1: the receive level with normal polarity is 1 on RTS
    chk("R1", "rts_idle", rts, 1);
    chk("R1", "wr_idle", fifo_wr, 0);
    den = 0;
    // R2
    md = 0;
    rx("R2", 8'hA5, 1); rx("R2", 8'h3C, 0);
    rxv = 1; rxd = 8'h11; cyc("R2"); rxv = 1; rxd = 8'h22; cyc("R2"); cyc("R2");
    // R3
    md = 1; aad = 0;
    rx("R3", 8'h07, 1); rx("R3", 8'h08, 0); rx("R3", 8'hFF, 1);
    // R4
    off = 1;
    rx("R4", 8'h55, 1); rx("R4", 8'h56, 0);
    off = 0;
    // R5 R6 R7
    aad = 1; match = 8'h5A;
    rx("R7", 8'h10, 0);
    rx("R6", 8'h33, 1);
    rx("R6", 8'h34, 0);
    rx("R5", 8'h5A, 1);
    rx("R7", 8'h40, 0);
    rx("R7", 8'h41, 0);
    off = 1; rx("R4", 8'h42, 0); off = 0;
    rx("R7", 8'h43, 0);
    rx("R6", 8'h5B, 1);
    rx("R6", 8'h44, 0);
    rx("R5", 8'h5A, 1);
    aad = 0; cyc("R7"); aad = 1; cyc("R7");
    rx("R7", 8'h45, 0);
    md = 0; aad = 0;
    // R8 R9 R10 R11 R12
    den = 1;
    for (int k = 0; k < 4; k++) begin
      sel = k[0]; inv = k[1]; hold = 3;
      rtsin = k[1]; dtrin = !k[1];
      cyc("R9");
      busy = 1; repeat (4) cyc("R8");
      busy = 0;
      for (int t = 0; t < 12; t++) begin tick = (t % 3 == 2); cyc("R10"); end
    end
    sel = 0; inv = 0; hold = 0;
    busy = 1; repeat (3) cyc("R11"); busy = 0; repeat (3) cyc("R11");
    hold = 2;
    busy = 1; repeat (3) cyc("R12"); busy = 0;
    tick = 1; cyc("R12"); cyc("R12");
    busy = 1; cyc("R12"); busy = 0; cyc("R12");
    tick = 1; cyc("R12"); cyc("R12"); tick = 1; cyc("R12"); repeat (3) cyc("R12");
    den = 0; busy = 1; cyc("R9"); busy = 0; repeat (4) begin tick = 1; cyc("R9"); end
    // random
    for (int n = 0; n < 4000; n++) begin
      if (n % 400 == 0) begin
        md = $urandom_range(0, 1); aad = $urandom_range(0, 1);
        den = $urandom_range(0, 1); sel = $urandom_range(0, 1); inv = $urandom_range(0, 1);
        match = $urandom_range(0, 255); hold = $urandom_range(0, 5);
        rtsin = $urandom_range(0, 1); dtrin = $urandom_range(0, 1);
      end
      off  = ($urandom_range(0, 19) == 0);
      rxv  = ($urandom_range(0, 3) == 0);
      rxd  = ($urandom_range(0, 2) == 0) ? match : 8'($urandom_range(0, 255));
      nin  = ($urandom_range(0, 2) == 0);
      tick = ($urandom_range(0, 4) == 0);
      if ($urandom_range(0, 19) == 0) busy = !busy;
      cyc("RND");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule